// File: doc/BRIEF.md
# Serial-Controlled Current-Loop DAC Register Interface

This block is the device-side digital front of a loop-powered current-output converter. A host talks to it over a four-wire serial bus in mode 0, one 24-bit frame per chip-select window. Each frame either writes a 16-bit value into a register or requests one. The requested value comes back in the following frame. Besides the code, control, offset-trim and gain-trim registers, the block holds a fault status word. That word collects raw fault conditions from the analog side, together with a framing error that the block detects itself. From the fault bits it drives a level-sensitive alert pin.

The serial pins are oversampled by the block's own clock through two-stage synchronizers, so the serial clock must run several times slower than the system clock. The code that drives the converter is a separate latch. It changes only on an explicit load command, so that a new code can be staged first and then applied in one step.

Top module: `loopdac_spi_slave`

## Requirements
- R1: A frame is 24 bits sent MSB first. MOSI is sampled on rising SCLK while cs_n is low, and cs_n rising ends the frame. Bit 23 set means read, bits 22:16 are the register address and bits 15:0 are the write data.
- R2: For a read, the 16-bit register value is shifted out on MISO in bits 15:0 of the next frame, and bits 23:16 of that frame are zero. The frame that follows any valid non-read frame returns all zeros. MISO changes after falling SCLK.
- R3: Address 1 (code), 3 (offset trim) and 4 (gain trim) store and return full 16-bit values. A read of any address other than 1 to 5 returns 0. Writes to 6, 8 and 9 change nothing.
- R4: The control register (address 2) keeps only bits 12, 11, 9, 8, 7 and 6, reads the other bits as 0, and drives ctrl_out.
- R5: A write to address 5 copies the code register to dac_out. Writing the code register alone leaves dac_out unchanged.
- R6: A read of address 5 returns the fault word: bit 15 framing error, bits 14 to 8 equal fault_in[6:0] (14 checksum error, 13 over-current, 12 under-current, 11 over-140 degrees, 10 over-100 degrees, 9 supply under 6 V, 8 supply under 12 V), bits 7:0 zero.
- R7: Fault bits latch while their condition is present. A read of address 5 clears every bit whose condition is absent at that moment.
- R8: fault_pin is high exactly while any of fault bits 15 to 11 is latched. Bits 10 to 8 never raise it.
- R9: A frame that ends after a nonzero number of clocks other than 24 sets fault bit 15 and changes no register and no pending read data.
- R10: A write to address 7 restores code 0, control 0, offset 0x8000 (zero correction), gain 0xFFFF and dac_out 0.
- R11: Synchronous reset gives the R10 defaults, clears all fault bits and pending read data, and holds MISO low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from the host |
| fault_in | input | 7 | Raw fault conditions, mapped to fault bits 14 to 8 |
| miso | output | 1 | Serial data to the host |
| fault_pin | output | 1 | Level alert for the severe fault bits |
| dac_out | output | 16 | Code applied to the converter |
| ctrl_out | output | 16 | Current control register value |

## Verification
The assertions assume that the serial pins move slowly compared with clk: each SCLK level and each cs_n level lasts several system clocks, and cs_n never moves in the same synchronized cycle as an SCLK edge. They also assume that fault_in is driven from clk-aligned logic. The bench drives every pin at the falling clk edge, holds each SCLK phase for six clocks and leaves idle gaps around cs_n. Because of this, each frame reaches the register logic as exactly one valid or one error pulse.

// File: rtl/loopdac_pkg.sv
package loopdac_pkg;
    localparam int FRAME_BITS = 24;
    localparam int DATA_W     = 16;
    localparam int ADDR_W     = 7;
    localparam int FIN_W      = 7;
    localparam int CNT_W      = $clog2(FRAME_BITS + 8);
    localparam int PAD_W      = FRAME_BITS - DATA_W;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_t;

    localparam logic [ADDR_W-1:0] A_CODE  = 7'd1;
    localparam logic [ADDR_W-1:0] A_CTRL  = 7'd2;
    localparam logic [ADDR_W-1:0] A_OFS   = 7'd3;
    localparam logic [ADDR_W-1:0] A_GAIN  = 7'd4;
    localparam logic [ADDR_W-1:0] A_FAULT = 7'd5;
    localparam logic [ADDR_W-1:0] A_RST   = 7'd7;

    localparam logic [DATA_W-1:0] CTRL_KEEP = 16'h1BC0;
    localparam logic [DATA_W-1:0] TRIP_SET  = 16'hF800;
    localparam logic [DATA_W-1:0] OFS_INIT  = 16'h8000;
    localparam logic [DATA_W-1:0] GAIN_INIT = 16'hFFFF;

    function automatic logic [DATA_W-1:0] fault_word(input logic spi_err,
                                                     input logic [FIN_W-1:0] cond);
        return {spi_err, cond, {(DATA_W-FIN_W-1){1'b0}}};
    endfunction
endpackage

// File: rtl/loopdac_serial.sv
module loopdac_serial
    import loopdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    input  logic [DATA_W-1:0] reply,
    output logic              miso,
    output logic              frm_ok,
    output logic              frm_bad,
    output frame_t            frm
);
    logic [2:0] sclk_s;
    logic [2:0] cs_s;
    logic [1:0] mosi_s;
    logic [FRAME_BITS-1:0] rx_q, tx_q;
    logic [CNT_W-1:0] cnt_q;

    wire active  = ~cs_s[1];
    wire cs_fall = ~cs_s[1] &  cs_s[2];
    wire cs_rise =  cs_s[1] & ~cs_s[2];
    wire s_rise  =  sclk_s[1] & ~sclk_s[2];
    wire s_fall  = ~sclk_s[1] &  sclk_s[2];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_s  <= 3'b000;
            cs_s    <= 3'b111;
            mosi_s  <= 2'b00;
            rx_q    <= '0;
            tx_q    <= '0;
            cnt_q   <= '0;
            frm_ok  <= 1'b0;
            frm_bad <= 1'b0;
        end else begin
            sclk_s  <= {sclk_s[1:0], sclk};
            cs_s    <= {cs_s[1:0], cs_n};
            mosi_s  <= {mosi_s[0], mosi};
            frm_ok  <= 1'b0;
            frm_bad <= 1'b0;
            if (cs_fall) begin
                cnt_q <= '0;
                tx_q  <= {{PAD_W{1'b0}}, reply};
            end else if (active) begin
                if (s_rise) begin
                    rx_q <= {rx_q[FRAME_BITS-2:0], mosi_s[1]};
                    if (cnt_q != {CNT_W{1'b1}}) cnt_q <= cnt_q + 1'b1;
                end
                if (s_fall) tx_q <= {tx_q[FRAME_BITS-2:0], 1'b0};
            end
            if (cs_rise) begin
                frm_ok  <= (cnt_q == CNT_W'(FRAME_BITS));
                frm_bad <= (cnt_q != '0) && (cnt_q != CNT_W'(FRAME_BITS));
            end
        end
    end

    assign miso = active ? tx_q[FRAME_BITS-1] : 1'b0;
    assign frm  = frame_t'(rx_q);

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frm_ok, frm_bad}));                                   // R9
    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
        cs_s[1] |-> !miso);                                              // R2
endmodule

// File: rtl/loopdac_regs.sv
module loopdac_regs
    import loopdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frm_ok,
    input  logic              frm_bad,
    input  frame_t            frm,
    input  logic [FIN_W-1:0]  fault_in,
    output logic [DATA_W-1:0] reply,
    output logic [DATA_W-1:0] dac_out,
    output logic [DATA_W-1:0] ctrl_out,
    output logic              fault_pin
);
    logic [DATA_W-1:0] code_q, ctrl_q, ofs_q, gain_q, dac_q, flt_q, hold_q;
    logic [DATA_W-1:0] flt_now, flt_seen, flt_next, rd_val;

    wire do_wr  = frm_ok & ~frm.rd;
    wire rd_flt = frm_ok &  frm.rd & (frm.addr == A_FAULT);

    assign flt_now  = fault_word(frm_bad, fault_in);
    assign flt_seen = flt_q | flt_now;
    assign flt_next = rd_flt ? flt_now : flt_seen;

    always_comb begin
        case (frm.addr)
            A_CODE:  rd_val = code_q;
            A_CTRL:  rd_val = ctrl_q;
            A_OFS:   rd_val = ofs_q;
            A_GAIN:  rd_val = gain_q;
            A_FAULT: rd_val = flt_seen;
            default: rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            ctrl_q <= '0;
            ofs_q  <= OFS_INIT;
            gain_q <= GAIN_INIT;
            dac_q  <= '0;
            flt_q  <= '0;
            hold_q <= '0;
        end else begin
            flt_q <= flt_next;
            if (frm_ok) hold_q <= frm.rd ? rd_val : '0;
            if (do_wr) begin
                case (frm.addr)
                    A_CODE:  code_q <= frm.data;
                    A_CTRL:  ctrl_q <= frm.data & CTRL_KEEP;
                    A_OFS:   ofs_q  <= frm.data;
                    A_GAIN:  gain_q <= frm.data;
                    A_FAULT: dac_q  <= code_q;
                    A_RST: begin
                        code_q <= '0;
                        ctrl_q <= '0;
                        ofs_q  <= OFS_INIT;
                        gain_q <= GAIN_INIT;
                        dac_q  <= '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign reply     = hold_q;
    assign dac_out   = dac_q;
    assign ctrl_out  = ctrl_q;
    assign fault_pin = |(flt_q & TRIP_SET);

    AST_CTRL_RSVD: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q & ~CTRL_KEEP) == '0);                                    // R4
    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (rst)
        !(do_wr && (frm.addr == A_FAULT || frm.addr == A_RST)) |=> $stable(dac_q)); // R5
    AST_PIN_TRIP: assert property (@(posedge clk) disable iff (rst)
        |(flt_now & TRIP_SET) |=> fault_pin);                            // R8
    AST_RST_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
        (do_wr && frm.addr == A_RST) |=> (ofs_q == OFS_INIT && gain_q == GAIN_INIT && dac_q == '0)); // R10
    AST_BAD_KEEPS: assert property (@(posedge clk) disable iff (rst)
        frm_bad |=> ($stable(code_q) && $stable(hold_q) && flt_q[DATA_W-1])); // R9
endmodule

// File: rtl/loopdac_spi_slave.sv
module loopdac_spi_slave
    import loopdac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        mosi,
    input  logic [6:0]  fault_in,
    output logic        miso,
    output logic        fault_pin,
    output logic [15:0] dac_out,
    output logic [15:0] ctrl_out
);
    logic              frm_ok, frm_bad;
    frame_t            frm;
    logic [DATA_W-1:0] reply;

    loopdac_serial u_serial (
        .clk     (clk),
        .rst     (rst),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .mosi    (mosi),
        .reply   (reply),
        .miso    (miso),
        .frm_ok  (frm_ok),
        .frm_bad (frm_bad),
        .frm     (frm)
    );

    loopdac_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .frm_ok    (frm_ok),
        .frm_bad   (frm_bad),
        .frm       (frm),
        .fault_in  (fault_in),
        .reply     (reply),
        .dac_out   (dac_out),
        .ctrl_out  (ctrl_out),
        .fault_pin (fault_pin)
    );
endmodule

// File: tb/loopdac_spi_slave_test.sv
module loopdac_spi_slave_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic [6:0]  fault_in = '0;
    logic        miso, fault_pin;
    logic [15:0] dac_out, ctrl_out;

    int n_run = 0;
    int n_bad = 0;
    logic [23:0] rx;

    localparam int HALF = 6;

    always #2 clk = ~clk;

    loopdac_spi_slave uut (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .fault_in(fault_in), .miso(miso), .fault_pin(fault_pin),
        .dac_out(dac_out), .ctrl_out(ctrl_out)
    );

    // {frame sent, expected bits 15:0 returned during that frame}
    localparam logic [39:0] VEC [10] = '{
        {24'h011234, 16'h0000},   // R3 write code
        {24'h810000, 16'h0000},   // R2 after write: zero
        {24'h04ABCD, 16'h1234},   // R2 R3 code read back
        {24'h840000, 16'h0000},
        {24'h830000, 16'hABCD},   // R3 gain read back
        {24'h02FFFF, 16'h8000},   // R11 offset default
        {24'h820000, 16'h0000},
        {24'h090000, 16'h1BC0},   // R4 control masked
        {24'h860000, 16'h0000},
        {24'h090000, 16'h0000}    // R3 unmapped address reads 0
    };

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [23:0] tx, input int nbits, output logic [23:0] got);
        got = '0;
        @(negedge clk);
        cs_n = 1'b0;
        idle(HALF);
        for (int b = 0; b < nbits; b++) begin
            mosi = tx[23-b];
            idle(HALF);
            got = {got[22:0], miso};
            sclk = 1'b1;
            idle(HALF);
            sclk = 1'b0;
        end
        idle(HALF);
        cs_n = 1'b1;
        idle(8);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end

    initial begin : main
        idle(4);
        rst = 1'b0;
        idle(2);
        check("R11 dac", {8'h0, dac_out}, 24'h0);
        check("R11 ctrl", {8'h0, ctrl_out}, 24'h0);
        check("R11 pins", {22'h0, miso, fault_pin}, 24'h0);

        for (int v = 0; v < 10; v++) begin
            xfer(VEC[v][39:16], 24, rx);
            check("R1 R2 table", rx, {8'h00, VEC[v][15:0]});
        end

        check("R4 ctrl_out", {8'h0, ctrl_out}, 24'h001BC0);
        check("R5 no load yet", {8'h0, dac_out}, 24'h0);
        xfer(24'h050000, 24, rx);
        check("R5 load", {8'h0, dac_out}, 24'h001234);

        fault_in = 7'b0000010;              // supply under 6 V -> bit 9
        idle(3);
        check("R8 low fault bit", {23'h0, fault_pin}, 24'h0);
        fault_in = 7'b0100010;              // plus over-current -> bit 13
        idle(3);
        check("R8 trip bit", {23'h0, fault_pin}, 24'h1);
        fault_in = '0;
        idle(3);
        check("R7 latched", {23'h0, fault_pin}, 24'h1);
        xfer(24'h850000, 24, rx);
        xfer(24'h850000, 24, rx);
        check("R6 fault word", rx, 24'h002200);
        check("R7 cleared pin", {23'h0, fault_pin}, 24'h0);
        xfer(24'h090000, 24, rx);
        check("R7 cleared word", rx, 24'h0);

        xfer(24'h01FFFF, 16, rx);           // short frame
        check("R9 pin", {23'h0, fault_pin}, 24'h1);
        xfer(24'h850000, 24, rx);
        xfer(24'h810000, 24, rx);
        check("R9 R6 spi bit", rx, 24'h008000);
        xfer(24'h090000, 24, rx);
        check("R9 code kept", rx, 24'h001234);
        check("R9 dac kept", {8'h0, dac_out}, 24'h001234);

        xfer(24'h06FFFF, 24, rx);           // R3 no-effect address
        xfer(24'h070000, 24, rx);
        check("R10 dac", {8'h0, dac_out}, 24'h0);
        check("R10 ctrl", {8'h0, ctrl_out}, 24'h0);
        xfer(24'h830000, 24, rx);
        xfer(24'h840000, 24, rx);
        check("R10 offset", rx, 24'h008000);
        xfer(24'h810000, 24, rx);
        check("R10 gain", rx, 24'h00FFFF);
        xfer(24'h090000, 24, rx);
        check("R10 code", rx, 24'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule